// File: doc/BRIEF.md
# Programmable Parallel Peripheral Interface

This block is a three-port parallel I/O controller that sits on a small CPU bus. The CPU selects one of four locations with a 2-bit address, qualified by an active-low chip select and active-low read and write strobes, and moves bytes over an 8-bit data bus. Locations 0, 1 and 2 are the data ports A, B and C. Location 3 is a write-only control location. Each external port has input pins, an output latch and one output enable per bit.

A byte written to the control location does one of two things. If bit 7 is set, it is a configuration word that sets the direction of each port and the mode of each group, and it clears every output latch. If bit 7 is clear, it is a single-bit command that sets or clears one port C latch bit. In the basic mode each port is a plain latch or a plain input. In the strobed-input mode, an external device loads port A or port B into a holding register by pulling a strobe pin low. Port C then reports buffer full and raises an interrupt request, and the CPU empties the buffer by reading the port. Strobed output and bidirectional operation are not part of this block.

Each strobed group runs its own handshake machine with four states. IDLE means empty and armed. CAPTURE means full with the strobe still low. FULL means full with the strobe released. DRAIN means emptied by a read while the strobe is still low. The transitions are: IDLE→CAPTURE on a low strobe, which also loads the pins. CAPTURE→FULL when the strobe goes high. CAPTURE or FULL→IDLE on a port read with the strobe high, or →DRAIN on a port read with the strobe low. DRAIN→IDLE when the strobe goes high. A configuration write, or leaving strobed mode, forces IDLE.

Top module: `ppi_core`

## Requirements
- R1: After reset all output latches are 0, every output enable is 0 (all ports are inputs), both groups are in basic mode, and rdata is 0 while no read is active.
- R2: A control write with bit 7 = 1 sets the configuration. Bits 6:5 give the group A mode: 01 is strobed, while 00 and 1x both act as basic. Bit 4 is the port A direction, bit 3 the direction of port C bits 7:4, bit 2 the group B mode (1 = strobed), bit 1 the port B direction and bit 0 the direction of port C bits 3:0. A direction bit of 1 means input, which gives output enable 0.
- R3: A configuration write clears all three output latches and empties both handshake buffers, including their interrupt requests.
- R4: A control write with bit 7 = 0 writes the value in bit 0 into the port C latch bit selected by bits 3:1. It leaves the configuration and the other latch bits unchanged.
- R5: In basic mode a read returns the pins for input bits and the latch for output bits (port C per nibble). A read of address 3 returns 0, and rdata is 0 outside a read.
- R6: A write to address 0, 1 or 2 loads that port's output latch once per write strobe, with the data present in the first cycle of the strobe.
- R7: With group A strobed and port A an input, a low level on pin PC4 while the buffer is empty loads the port A pins into the holding register. PC5 (buffer full) is high from the next cycle. While full, the held byte ignores further pin changes and strobe pulses, and port A reads return it.
- R8: The falling edge of the read strobe at address 0 while full clears PC5 and PC3. If PC4 is still low at that point, no new byte is taken until PC4 has been high.
- R9: PC3 (interrupt request A) rises together with buffer full only when port C latch bit 4 (interrupt enable A) is 1.
- R10: Group B strobed with port B an input behaves the same way, with PC2 as the strobe, PC1 as buffer full, PC0 as the interrupt request and port C latch bit 2 as the interrupt enable. It is emptied by a read of address 1.
- R11: In strobed mode a read of port C returns the live buffer-full and interrupt flags at their bit positions, and the interrupt enable at the strobe position. The other bits follow R5.
- R12: In strobed mode the strobe pin's output enable is 0 and the buffer-full and interrupt pins' output enables are 1, whatever the nibble direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Location: 0 port A, 1 port B, 2 port C, 3 control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when no read is active |
| pa_in | input | 8 | Port A pins |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pins |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pins, including the strobe inputs |
| pc_out | output | 8 | Port C latch, or handshake flags in strobed mode |
| pc_oe | output | 8 | Port C output enables |

## Verification
The assertions check, on every cycle, the effects of control writes on the direction and latch outputs, that a single-bit command keeps the directions, the single-load write rule, the pin roles in strobed mode, and that an interrupt request is never high without its buffer-full flag. Only the bench scenarios can show what the held data is worth. They show the byte taken at the strobe surviving later pin changes, a strobe held low across a read not loading twice, the enable bit gating the interrupt, and the port C read image mixing pins, latch and flags.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int NUM_GRP = 2;
    localparam int NIB_W   = DATA_W / 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_A    = 2'd0,
        SEL_B    = 2'd1,
        SEL_C    = 2'd2,
        SEL_CTRL = 2'd3
    } sel_t;

    typedef enum logic [1:0] {
        HS_IDLE,
        HS_CAPTURE,
        HS_FULL,
        HS_DRAIN
    } hs_state_t;

    // configuration fields; the packing matches the control word bits 6:0
    typedef struct packed {
        logic [1:0] mode_a;
        logic       dir_a;
        logic       dir_cu;
        logic       mode_b;
        logic       dir_b;
        logic       dir_cl;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{mode_a: 2'b00, dir_a: 1'b1, dir_cu: 1'b1,
                                   mode_b: 1'b0, dir_b: 1'b1, dir_cl: 1'b1};

    // port C roles of the handshake lines
    localparam int A_STB = 4;
    localparam int A_IBF = 5;
    localparam int A_INT = 3;
    localparam int B_STB = 2;
    localparam int B_IBF = 1;
    localparam int B_INT = 0;
endpackage

// File: rtl/ppi_bus_if.sv
module ppi_bus_if (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic rd_n,
    input  logic wr_n,
    output logic rd_act,
    output logic rd_evt,
    output logic wr_evt
);
    logic rd_q;
    logic wr_q;
    logic wr_act;

    assign rd_act = !cs_n && !rd_n;
    assign wr_act = !cs_n && !wr_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= 1'b0;
            wr_q <= 1'b0;
        end else begin
            rd_q <= rd_act;
            wr_q <= wr_act;
        end
    end

    // one event per strobe, in its first cycle
    assign rd_evt = rd_act && !rd_q;
    assign wr_evt = wr_act && !wr_q;
endmodule

// File: rtl/ppi_ctrl.sv
module ppi_ctrl
    import ppi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_evt,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output cfg_t              cfg,
    output logic [DATA_W-1:0] lat_a,
    output logic [DATA_W-1:0] lat_b,
    output logic [DATA_W-1:0] lat_c,
    output logic              mode_set
);
    sel_t sel;
    logic bsr;
    logic [2:0] bsr_idx;

    assign sel      = sel_t'(addr);
    assign mode_set = wr_evt && (sel == SEL_CTRL) && wdata[DATA_W-1];
    assign bsr      = wr_evt && (sel == SEL_CTRL) && !wdata[DATA_W-1];
    assign bsr_idx  = wdata[3:1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg   <= CFG_RESET;
            lat_a <= '0;
            lat_b <= '0;
            lat_c <= '0;
        end else if (mode_set) begin
            cfg   <= cfg_t'(wdata[6:0]);
            lat_a <= '0;
            lat_b <= '0;
            lat_c <= '0;
        end else if (bsr) begin
            lat_c[bsr_idx] <= wdata[0];
        end else if (wr_evt) begin
            unique case (sel)
                SEL_A:    lat_a <= wdata;
                SEL_B:    lat_b <= wdata;
                SEL_C:    lat_c <= wdata;
                SEL_CTRL: lat_c <= lat_c;
            endcase
        end
    end
endmodule

// File: rtl/ppi_strobe_in.sv
module ppi_strobe_in
    import ppi_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         enable,
    input  logic         stb_n,
    input  logic         inte,
    input  logic         rd_evt,
    input  logic [W-1:0] pins,
    output logic [W-1:0] held,
    output logic         ibf,
    output logic         intr
);
    hs_state_t st_q;
    hs_state_t st_d;
    logic      take;
    logic      flush;

    assign flush = clear || !enable;
    assign take  = !flush && (st_q == HS_IDLE) && !stb_n;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            HS_IDLE:    if (!stb_n) st_d = HS_CAPTURE;
            HS_CAPTURE: begin
                if (rd_evt)     st_d = stb_n ? HS_IDLE : HS_DRAIN;
                else if (stb_n) st_d = HS_FULL;
            end
            HS_FULL:    if (rd_evt) st_d = stb_n ? HS_IDLE : HS_DRAIN;
            HS_DRAIN:   if (stb_n) st_d = HS_IDLE;
        endcase
        if (flush) st_d = HS_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= HS_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held <= '0;
            intr <= 1'b0;
        end else begin
            if (take) held <= pins;
            if (flush)       intr <= 1'b0;
            else if (take)   intr <= inte;
            else if (rd_evt) intr <= 1'b0;
        end
    end

    assign ibf = (st_q == HS_CAPTURE) || (st_q == HS_FULL);
endmodule

// File: rtl/ppi_core.sv
module ppi_core
    import ppi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] pa_in,
    output logic [DATA_W-1:0] pa_out,
    output logic [DATA_W-1:0] pa_oe,
    input  logic [DATA_W-1:0] pb_in,
    output logic [DATA_W-1:0] pb_out,
    output logic [DATA_W-1:0] pb_oe,
    input  logic [DATA_W-1:0] pc_in,
    output logic [DATA_W-1:0] pc_out,
    output logic [DATA_W-1:0] pc_oe
);
    logic              rd_act;
    logic              rd_evt;
    logic              wr_evt;
    logic              mode_set;
    cfg_t              cfg;
    logic [DATA_W-1:0] lat_a;
    logic [DATA_W-1:0] lat_b;
    logic [DATA_W-1:0] lat_c;
    sel_t              sel;
    logic              strb_a;
    logic              strb_b;

    logic [NUM_GRP-1:0] grp_en;
    logic [NUM_GRP-1:0] grp_stb_n;
    logic [NUM_GRP-1:0] grp_inte;
    logic [NUM_GRP-1:0] grp_rd;
    logic [NUM_GRP-1:0] grp_ibf;
    logic [NUM_GRP-1:0] grp_intr;
    logic [DATA_W-1:0]  grp_pins [NUM_GRP];
    logic [DATA_W-1:0]  grp_held [NUM_GRP];

    logic [DATA_W-1:0] c_rd;
    logic [DATA_W-1:0] a_rd;
    logic [DATA_W-1:0] b_rd;

    assign sel = sel_t'(addr);

    ppi_bus_if u_bus (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .rd_act (rd_act),
        .rd_evt (rd_evt),
        .wr_evt (wr_evt)
    );

    ppi_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_evt   (wr_evt),
        .addr     (addr),
        .wdata    (wdata),
        .cfg      (cfg),
        .lat_a    (lat_a),
        .lat_b    (lat_b),
        .lat_c    (lat_c),
        .mode_set (mode_set)
    );

    // strobed handshake only for an input port; 1x in the group A mode acts as basic
    assign strb_a = (cfg.mode_a == 2'b01) && cfg.dir_a;
    assign strb_b = cfg.mode_b && cfg.dir_b;

    assign grp_en      = {strb_b, strb_a};
    assign grp_stb_n   = {pc_in[B_STB], pc_in[A_STB]};
    assign grp_inte    = {lat_c[B_STB], lat_c[A_STB]};
    assign grp_rd      = {rd_evt && (sel == SEL_B), rd_evt && (sel == SEL_A)};
    assign grp_pins[0] = pa_in;
    assign grp_pins[1] = pb_in;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_hs
        ppi_strobe_in #(.W(DATA_W)) u_hs (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear  (mode_set),
            .enable (grp_en[g]),
            .stb_n  (grp_stb_n[g]),
            .inte   (grp_inte[g]),
            .rd_evt (grp_rd[g]),
            .pins   (grp_pins[g]),
            .held   (grp_held[g]),
            .ibf    (grp_ibf[g]),
            .intr   (grp_intr[g])
        );
    end

    assign pa_out = lat_a;
    assign pb_out = lat_b;
    assign pa_oe  = {DATA_W{!cfg.dir_a}};
    assign pb_oe  = {DATA_W{!cfg.dir_b}};

    always_comb begin
        pc_out = lat_c;
        pc_oe  = {{NIB_W{!cfg.dir_cu}}, {NIB_W{!cfg.dir_cl}}};
        if (strb_a) begin
            pc_out[A_IBF] = grp_ibf[0];
            pc_out[A_INT] = grp_intr[0];
            pc_oe[A_IBF]  = 1'b1;
            pc_oe[A_INT]  = 1'b1;
            pc_oe[A_STB]  = 1'b0;
        end
        if (strb_b) begin
            pc_out[B_IBF] = grp_ibf[1];
            pc_out[B_INT] = grp_intr[1];
            pc_oe[B_IBF]  = 1'b1;
            pc_oe[B_INT]  = 1'b1;
            pc_oe[B_STB]  = 1'b0;
        end
    end

    always_comb begin
        c_rd = (pc_oe & lat_c) | (~pc_oe & pc_in);
        if (strb_a) begin
            c_rd[A_IBF] = grp_ibf[0];
            c_rd[A_INT] = grp_intr[0];
            c_rd[A_STB] = lat_c[A_STB];
        end
        if (strb_b) begin
            c_rd[B_IBF] = grp_ibf[1];
            c_rd[B_INT] = grp_intr[1];
            c_rd[B_STB] = lat_c[B_STB];
        end
    end

    assign a_rd = strb_a ? grp_held[0] : (cfg.dir_a ? pa_in : lat_a);
    assign b_rd = strb_b ? grp_held[1] : (cfg.dir_b ? pb_in : lat_b);

    always_comb begin
        rdata = '0;
        if (rd_act) begin
            unique case (sel)
                SEL_A:    rdata = a_rd;
                SEL_B:    rdata = b_rd;
                SEL_C:    rdata = c_rd;
                SEL_CTRL: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/ppi_core_chk.sv
module ppi_core_chk
    import ppi_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              rd_n,
    input logic              wr_n,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] pa_out,
    input logic [DATA_W-1:0] pa_oe,
    input logic [DATA_W-1:0] pb_out,
    input logic [DATA_W-1:0] pb_oe,
    input logic [DATA_W-1:0] pc_out,
    input logic [DATA_W-1:0] pc_oe,
    input logic              strb_a,
    input logic              strb_b
);
    logic wq;
    logic rq;
    logic wr_e;
    logic rd_e;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wq <= 1'b0;
            rq <= 1'b0;
        end else begin
            wq <= !cs_n && !wr_n;
            rq <= !cs_n && !rd_n;
        end
    end

    assign wr_e = !cs_n && !wr_n && !wq;
    assign rd_e = !cs_n && !rd_n && !rq;

    a_r2_dir_after_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_e && addr == 2'd3 && wdata[7]) |=>
            (pa_oe == {DATA_W{!$past(wdata[4])}}) && (pb_oe == {DATA_W{!$past(wdata[1])}}));

    a_r3_cfg_clears_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_e && addr == 2'd3 && wdata[7]) |=> (pa_out == '0) && (pb_out == '0));

    a_r4_bsr_keeps_dirs: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_e && addr == 2'd3 && !wdata[7]) |=> $stable(pa_oe) && $stable(pb_oe));

    a_r6_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_e && addr == 2'd0) |=> (pa_out == $past(wdata)));

    a_r8_read_empties_a: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_a && pc_out[A_IBF] && rd_e && !wr_e && addr == 2'd0) |=> !pc_out[A_IBF] && !pc_out[A_INT]);

    a_r9_intr_needs_full_a: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_a && pc_out[A_INT]) |-> pc_out[A_IBF]);

    a_r10_intr_needs_full_b: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_b && pc_out[B_INT]) |-> pc_out[B_IBF]);

    a_r12_roles_a: assert property (@(posedge clk) disable iff (!rst_n)
        strb_a |-> (pc_oe[A_IBF] && pc_oe[A_INT] && !pc_oe[A_STB]));

    a_r12_roles_b: assert property (@(posedge clk) disable iff (!rst_n)
        strb_b |-> (pc_oe[B_IBF] && pc_oe[B_INT] && !pc_oe[B_STB]));
endmodule

bind ppi_core ppi_core_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .addr   (addr),
    .wdata  (wdata),
    .pa_out (pa_out),
    .pa_oe  (pa_oe),
    .pb_out (pb_out),
    .pb_oe  (pb_oe),
    .pc_out (pc_out),
    .pc_oe  (pc_oe),
    .strb_a (strb_a),
    .strb_b (strb_b)
);

// File: tb/ppi_core_tb_top.sv
`timescale 1ns/1ps
module ppi_core_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] pa_in = 8'h00;
    logic [7:0] pb_in = 8'h00;
    logic [7:0] pc_in = 8'hFF;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #2.5 clk = ~clk;

    ppi_core dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; cs_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; cs_n = 1'b0; rd_n = 1'b0;
        #1 d = rdata;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    function automatic logic [7:0] oe_of(input logic dir);
        return dir ? 8'h00 : 8'hFF;
    endfunction

    function automatic logic [7:0] c_oe_of(input logic [7:0] ctrl);
        return {ctrl[3] ? 4'h0 : 4'hF, ctrl[0] ? 4'h0 : 4'hF};
    endfunction

    function automatic logic [7:0] mix_c(input logic [7:0] ctrl, input logic [7:0] pins,
                                         input logic [7:0] lat);
        return {ctrl[3] ? pins[7:4] : lat[7:4], ctrl[0] ? pins[3:0] : lat[3:0]};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic [7:0] ctrl, la, lb, lc;
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pa_oe", pa_oe, 8'h00);
        check("R1 pb_oe", pb_oe, 8'h00);
        check("R1 pc_oe", pc_oe, 8'h00);
        check("R1 latches", pa_out | pb_out | pc_out, 8'h00);
        check("R1 idle rdata", rdata, 8'h00);
        pa_in = 8'h3C;
        bus_read(2'd0, rd);
        check("R1 port A reads pins", rd, 8'h3C);

        // constrained random basic-mode traffic
        for (int it = 0; it < 30; it++) begin
            ctrl = 8'($urandom);
            ctrl[7] = 1'b1;
            ctrl[5] = 1'b0;          // group A mode 00 or 10, both basic
            ctrl[2] = 1'b0;          // group B basic
            bus_write(2'd3, ctrl);
            check("R3 latches cleared", pa_out | pb_out | pc_out, 8'h00);
            check("R2 pa_oe", pa_oe, oe_of(ctrl[4]));
            check("R2 pb_oe", pb_oe, oe_of(ctrl[1]));
            check("R2 pc_oe", pc_oe, c_oe_of(ctrl));
            la = 8'($urandom); lb = 8'($urandom); lc = 8'($urandom);
            bus_write(2'd0, la);
            bus_write(2'd1, lb);
            bus_write(2'd2, lc);
            check("R6 pa_out", pa_out, la);
            check("R6 pb_out", pb_out, lb);
            check("R6 pc_out", pc_out, lc);
            pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
            bus_read(2'd0, rd);
            check("R5 read A", rd, ctrl[4] ? pa_in : la);
            bus_read(2'd1, rd);
            check("R5 read B", rd, ctrl[1] ? pb_in : lb);
            bus_read(2'd2, rd);
            check("R5 read C", rd, mix_c(ctrl, pc_in, lc));
            bus_read(2'd3, rd);
            check("R5 read ctrl", rd, 8'h00);
            begin
                logic [2:0] n;
                logic       v;
                n = 3'($urandom);
                v = 1'($urandom);
                bus_write(2'd3, {4'h0, n, v});
                lc[n] = v;
                check("R4 bsr latch", pc_out, lc);
                check("R4 bsr keeps A dir", pa_oe, oe_of(ctrl[4]));
                check("R4 bsr keeps C dir", pc_oe, c_oe_of(ctrl));
            end
        end

        // R6 one load per strobe
        @(negedge clk);
        addr = 2'd0; wdata = 8'h12; cs_n = 1'b0; wr_n = 1'b0;
        @(negedge clk); wdata = 8'h34;
        @(negedge clk); wdata = 8'h56;
        @(negedge clk); cs_n = 1'b1; wr_n = 1'b1;
        check("R6 single load", pa_out, 8'h12);

        // group A strobed input, C outputs
        pc_in = 8'hFF;
        bus_write(2'd3, 8'hB0);
        check("R12 A roles pc_oe", pc_oe, 8'hEF);
        check("R3 A empty", pc_out, 8'h00);
        bus_write(2'd3, 8'h09);              // interrupt enable A on
        check("R9 no intr yet", {7'h0, pc_out[3]}, 8'h00);
        pa_in = 8'h5A;
        @(negedge clk); pc_in[4] = 1'b0;
        @(negedge clk);
        check("R7 ibf set", {7'h0, pc_out[5]}, 8'h01);
        check("R9 intr set", {7'h0, pc_out[3]}, 8'h01);
        pa_in = 8'hFF;
        pc_in[4] = 1'b1;
        @(negedge clk); pa_in = 8'h11; pc_in[4] = 1'b0;
        @(negedge clk); pc_in[4] = 1'b1;
        bus_read(2'd2, rd);
        check("R11 C image A full", rd, 8'h38);
        bus_read(2'd0, rd);
        check("R7 held byte", rd, 8'h5A);
        check("R8 ibf cleared", {7'h0, pc_out[5]}, 8'h00);
        check("R8 intr cleared", {7'h0, pc_out[3]}, 8'h00);

        bus_write(2'd3, 8'h08);              // interrupt enable A off
        pa_in = 8'h77;
        @(negedge clk); pc_in[4] = 1'b0;
        @(negedge clk);
        check("R9 ibf without intr", {6'h0, pc_out[5], pc_out[3]}, 8'h02);
        bus_read(2'd0, rd);
        check("R7 second byte", rd, 8'h77);
        pa_in = 8'h99;
        repeat (2) @(negedge clk);
        check("R8 no reload while low", {7'h0, pc_out[5]}, 8'h00);
        pc_in[4] = 1'b1;
        @(negedge clk);
        check("R8 still empty", {7'h0, pc_out[5]}, 8'h00);
        pc_in[4] = 1'b0;
        @(negedge clk);
        pc_in[4] = 1'b1;
        check("R8 rearmed", {7'h0, pc_out[5]}, 8'h01);
        bus_read(2'd0, rd);
        check("R8 rearmed byte", rd, 8'h99);

        // group B strobed input, C lower nibble input
        bus_write(2'd3, 8'h87);
        check("R12 B roles pc_oe", pc_oe, 8'hF3);
        bus_write(2'd3, 8'h05);              // interrupt enable B on
        pb_in = 8'hC3;
        @(negedge clk); pc_in[2] = 1'b0;
        @(negedge clk); pc_in[2] = 1'b1;
        check("R10 ibf and intr", {6'h0, pc_out[1], pc_out[0]}, 8'h03);
        bus_read(2'd2, rd);
        check("R11 C image B full", rd, 8'h0F);
        pb_in = 8'h00;
        bus_read(2'd1, rd);
        check("R10 held byte", rd, 8'hC3);
        check("R10 cleared", {6'h0, pc_out[1], pc_out[0]}, 8'h00);
        bus_write(2'd3, 8'h05);
        @(negedge clk); pc_in[2] = 1'b0;
        @(negedge clk); pc_in[2] = 1'b1;
        bus_write(2'd3, 8'h87);
        check("R3 cfg empties B", {6'h0, pc_out[1], pc_out[0]}, 8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule